// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash bus. Once software or a sequencer has finished writing a program or erase command sequence to the flash, it pulses `startReq` along with the operation type, the data that was programmed, a polling address and a poll budget. The poller waits a fixed settling interval and then reads the flash again and again at that address. It looks at the status bit (bit 7) in each returned word and decides whether the operation completed, failed or is still running.

When a program operation finishes, the status bit reads back as the programmed value of that bit. When an erase finishes, it reads back as 1. The flash may report completion on a read whose other bits are not yet valid. For that reason, every successful decision is followed by one more read, and that later word is returned as the result. Bit 5 is the flash's time-limit flag. When it is set and bit 7 has not matched, the poller does one confirming read before declaring failure, because the operation may have completed in the gap between the two bits. A poll budget ends the operation as a failure if neither condition ever appears.

For erase, the caller must supply an address inside a sector that is being erased and is not protected. The poller does not check this.

Top module: `fpoll_top`

## Requirements
- R1: When reset is released, `busy`, `done`, `pass`, `fail` and `rdReq` are all 0.
- R2: `startReq` is accepted only when the block is idle or done. A pulse while `busy` is 1 has no effect on the read sequence, the read address or the outcome.
- R3: On an accepted start, the block latches `opErase`, bit 7 of `expData`, `pollAddr` and `maxPolls`. Later changes to these inputs have no effect on the running operation. The first `rdReq` appears in cycle SETTLE_CYCLES+1 after the accepting clock edge. Every read drives `rdAddr` with the latched address.
- R4: Each read is a one-cycle `rdReq` pulse. The flash returns `rdData` in the following cycle, and the block evaluates it in that cycle, so `rdReq` is never high in two consecutive cycles. While polling, primary reads repeat every 2 cycles.
- R5: For a program (`opErase`=0), a read whose bit 7 equals latched `expData[7]` counts as completion.
- R6: For an erase (`opErase`=1), a read whose bit 7 is 1 counts as completion, whatever `expData` holds. A completion match takes priority over bit 5.
- R7: After a completion match, the block performs exactly one more read and returns that word on `resultData` with `pass`=1.
- R8: When bit 7 does not match and bit 5 is 1, the block performs one confirming read. If that read's bit 7 matches, the R7 final read follows. Otherwise the block ends with `fail`=1 and the confirming word on `resultData`.
- R9: After `maxPolls` primary reads with neither a match nor bit 5 set, the block ends with `fail`=1 and the last word on `resultData`. A `maxPolls` of 0 behaves as 1.
- R10: `done` holds at 1 with exactly one of `pass`/`fail` set, and `resultData` holds steady, until the next accepted start. That start clears `pass` and `fail` on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse after the command sequence has been written |
| opErase | input | 1 | 1 = erase operation, 0 = program operation |
| expData | input | DATA_W | Data that was programmed (bit 7 used) |
| pollAddr | input | ADDR_W | Address to poll |
| maxPolls | input | CNT_W | Budget of primary reads (0 treated as 1) |
| rdReq | output | 1 | One-cycle flash read request |
| rdAddr | output | ADDR_W | Flash read address |
| rdData | input | DATA_W | Flash read word, valid the cycle after `rdReq` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result available |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed or exhausted its budget |
| resultData | output | DATA_W | Final word read |

## Verification
The bench feeds scripted flash response sequences to the block. These include program targets with bit 7 set and with bit 7 clear, and an erase whose `expData` would falsely pass as a program, which shows the target bit is chosen by operation type. Bit-5 sequences are paired two ways: one with a confirming read that matches and one with a confirming read that does not, which separates the confirm-then-pass path from the confirm-then-fail path. A word with both bit 7 and bit 5 set shows that the match takes priority. Budget runs with `maxPolls` of 3 and 0 show the limit, and the final-read words always differ from the status words, so the bench can tell which read was returned. The inputs are scrambled after each start and a second start is injected mid-run, which shows the parameters are latched and that a start while busy is ignored.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_VALID,
    ST_READ,
    ST_CHECK,
    ST_REREAD,
    ST_DONE
  } pollState_t;

  // Which kind of read the word in the CHECK state came from
  typedef enum logic [1:0] {
    CK_PRIMARY,
    CK_CONFIRM,
    CK_FINAL
  } checkKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic waitStep;
    logic countPoll;
    logic keepWord;
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic waitDone;
    logic bitMatch;
    logic limitFlag;
    logic pollsUsed;
  } dpStat_t;

endpackage

// File: rtl/fpoll_datapath.sv
module fpoll_datapath
  import fpoll_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 18,
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int STAT_BIT      = 7,
  parameter int LIMIT_BIT     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              opErase,
  input  logic              expBit,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] resultData,
  output dpStat_t           stat
);

  localparam int WAIT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic              eraseQ;
  logic              expBitQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  budgetQ;
  logic [WAIT_W-1:0] waitCnt;
  logic [CNT_W-1:0]  pollCnt;
  logic [DATA_W-1:0] resultQ;
  logic              targetBit;
  logic [CNT_W-1:0]  effBudget;

  // Command capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseQ  <= 1'b0;
      expBitQ <= 1'b0;
      addrQ   <= '0;
      budgetQ <= '0;
    end else if (ctl.latchCmd) begin
      eraseQ  <= opErase;
      expBitQ <= expBit;
      addrQ   <= pollAddr;
      budgetQ <= maxPolls;
    end
  end

  // Settling counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.latchCmd) begin
      waitCnt <= WAIT_LOAD;
    end else if (ctl.waitStep && (waitCnt != '0)) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  // Primary poll counter (saturating)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (ctl.latchCmd) begin
      pollCnt <= '0;
    end else if (ctl.countPoll && (pollCnt != CNT_MAX)) begin
      pollCnt <= pollCnt + CNT_ONE;
    end
  end

  // Result word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (ctl.keepWord) begin
      resultQ <= rdData;
    end
  end

  always_comb begin
    targetBit      = eraseQ ? 1'b1 : expBitQ;
    effBudget      = (budgetQ == '0) ? CNT_ONE : budgetQ;
    stat.waitDone  = (waitCnt == '0);
    stat.bitMatch  = (rdData[STAT_BIT] == targetBit);
    stat.limitFlag = rdData[LIMIT_BIT];
    stat.pollsUsed = (pollCnt >= effBudget);
  end

  assign rdAddr     = addrQ;
  assign resultData = resultQ;

endmodule

// File: rtl/fpoll_control.sv
module fpoll_control
  import fpoll_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    rdReq,
  output logic    busy,
  output logic    done,
  output logic    pass,
  output logic    fail
);

  pollState_t state, nextState;
  checkKind_t kind, nextKind;
  logic       passQ, failQ;
  logic       setPass, setFail;

  always_comb begin
    nextState = state;
    nextKind  = kind;
    ctl       = '0;
    rdReq     = 1'b0;
    setPass   = 1'b0;
    setFail   = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          ctl.latchCmd = 1'b1;
          nextState    = ST_WAIT_VALID;
        end
      end
      ST_WAIT_VALID: begin
        if (stat.waitDone) begin
          nextState = ST_READ;
          nextKind  = CK_PRIMARY;
        end else begin
          ctl.waitStep = 1'b1;
        end
      end
      ST_READ: begin
        rdReq         = 1'b1;
        ctl.countPoll = 1'b1;
        nextState     = ST_CHECK;
      end
      ST_REREAD: begin
        rdReq     = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (kind == CK_FINAL) begin
          ctl.keepWord = 1'b1;
          setPass      = 1'b1;
          nextState    = ST_DONE;
        end else if (stat.bitMatch) begin
          nextState = ST_REREAD;
          nextKind  = CK_FINAL;
        end else if (kind == CK_CONFIRM) begin
          ctl.keepWord = 1'b1;
          setFail      = 1'b1;
          nextState    = ST_DONE;
        end else if (stat.limitFlag) begin
          nextState = ST_REREAD;
          nextKind  = CK_CONFIRM;
        end else if (stat.pollsUsed) begin
          ctl.keepWord = 1'b1;
          setFail      = 1'b1;
          nextState    = ST_DONE;
        end else begin
          nextState = ST_READ;
          nextKind  = CK_PRIMARY;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= CK_PRIMARY;
      passQ <= 1'b0;
      failQ <= 1'b0;
    end else begin
      state <= nextState;
      kind  <= nextKind;
      if (ctl.latchCmd) begin
        passQ <= 1'b0;
        failQ <= 1'b0;
      end else begin
        if (setPass) passQ <= 1'b1;
        if (setFail) failQ <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);
  assign pass = passQ;
  assign fail = failQ;

endmodule

// File: rtl/fpoll_top.sv
module fpoll_top
  import fpoll_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 18,
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              opErase,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] resultData
);

  localparam int STAT_BIT  = 7;
  localparam int LIMIT_BIT = 5;

  dpCtl_t  ctl;
  dpStat_t stat;

  fpoll_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stat     (stat),
    .ctl      (ctl),
    .rdReq    (rdReq),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail     (fail)
  );

  fpoll_datapath #(
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .CNT_W         (CNT_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .STAT_BIT      (STAT_BIT),
    .LIMIT_BIT     (LIMIT_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .opErase    (opErase),
    .expBit     (expData[STAT_BIT]),
    .pollAddr   (pollAddr),
    .maxPolls   (maxPolls),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .resultData (resultData),
    .stat       (stat)
  );

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [DATA_W-1:0] resultData
);

  assert_outcome_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fail));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!pass && !fail));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> (done && $stable(pass) && $stable(resultData)));

  assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  assert_read_when_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (busy && !done));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr));

  assert_no_abort_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  assert_final_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pass) |-> $past(rdReq, 2));

endmodule

bind fpoll_top fpoll_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .rdReq      (rdReq),
  .rdAddr     (rdAddr),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .fail       (fail),
  .resultData (resultData)
);

// File: tb/fpoll_top_bench.sv
`timescale 1ns/1ps
module fpoll_top_bench;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 18;
  localparam int CNT_W  = 16;
  localparam int SETTLE = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic              opErase = 1'b0;
  logic [DATA_W-1:0] expData = '0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic [CNT_W-1:0]  maxPolls = '0;
  logic              rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData = '0;
  logic              busy, done, pass, fail;
  logic [DATA_W-1:0] resultData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit overRead = 1'b0;

  logic [DATA_W-1:0] flashQ[$];
  bit                expTrace[$];
  bit                expPass;
  logic [DATA_W-1:0] expFinal;

  always #2 clk = ~clk;

  fpoll_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE)) u_fpoll_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opErase(opErase), .expData(expData),
    .pollAddr(pollAddr), .maxPolls(maxPolls), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .resultData(resultData)
  );

  // Flash model: answers each read request in the next cycle
  always @(posedge clk) begin
    if (rdReq) begin
      if (flashQ.size() > 0) rdData <= flashQ.pop_front();
      else begin
        rdData   <= '0;
        overRead <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: predicts the per-cycle read pattern and the outcome
  task automatic predict(input bit er, input logic [7:0] ex, input int mp,
                         input logic [7:0] resp[$]);
    int idx = 0;
    int polls = 0;
    int budget = (mp == 0) ? 1 : mp;
    bit tgt = er ? 1'b1 : ex[7];
    logic [7:0] w;
    expTrace.delete();
    repeat (SETTLE) expTrace.push_back(1'b0);
    forever begin
      expTrace.push_back(1'b1); expTrace.push_back(1'b0);
      w = resp[idx]; idx++; polls++;
      if (w[7] == tgt) begin
        expTrace.push_back(1'b1); expTrace.push_back(1'b0);
        expFinal = resp[idx]; expPass = 1'b1;
        break;
      end
      if (w[5]) begin
        expTrace.push_back(1'b1); expTrace.push_back(1'b0);
        w = resp[idx]; idx++;
        if (w[7] == tgt) begin
          expTrace.push_back(1'b1); expTrace.push_back(1'b0);
          expFinal = resp[idx]; expPass = 1'b1;
        end else begin
          expFinal = w; expPass = 1'b0;
        end
        break;
      end
      if (polls >= budget) begin
        expFinal = w; expPass = 1'b0;
        break;
      end
    end
  endtask

  task automatic runCase(input string tag, input bit er, input logic [7:0] ex,
                         input logic [ADDR_W-1:0] addr, input int mp,
                         input logic [7:0] resp[$], input bit intrude);
    predict(er, ex, mp, resp);
    flashQ   = resp;
    overRead = 1'b0;
    opErase  = er;
    expData  = ex;
    pollAddr = addr;
    maxPolls = CNT_W'(mp);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    // R3: scramble command inputs after acceptance
    opErase  = ~er;
    expData  = ~ex;
    pollAddr = ~addr;
    maxPolls = '1;
    for (int k = 0; k < expTrace.size(); k++) begin
      chk(rdReq === expTrace[k], "R4", {tag, " read pattern"}, 32'(rdReq), 32'(expTrace[k]));
      chk(done === 1'b0 && busy === 1'b1, "R2", {tag, " busy during run"}, {30'd0, busy, done}, 32'h2);
      if (k == 0) chk(pass === 1'b0 && fail === 1'b0, "R10", {tag, " flags cleared"}, {30'd0, pass, fail}, 32'h0);
      if (rdReq) chk(rdAddr === addr, "R3", {tag, " read address"}, 32'(rdAddr), 32'(addr));
      if (intrude && k == 3) startReq = 1'b1;
      if (intrude && k == 4) startReq = 1'b0;
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0, "R10", {tag, " done"}, {30'd0, busy, done}, 32'h1);
    chk(pass === expPass && fail === !expPass, tag, "outcome", {30'd0, pass, fail}, {30'd0, expPass, !expPass});
    chk(resultData === expFinal, tag, "result word", 32'(resultData), 32'(expFinal));
    chk(flashQ.size() == 0 && !overRead, tag, "reads consumed", 32'(flashQ.size()), 32'd0);
    @(negedge clk);
    chk(done === 1'b1 && pass === expPass && resultData === expFinal, "R10", {tag, " hold"},
        {23'd0, done, resultData}, {23'd0, 1'b1, expFinal});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !rdReq, "R1", "reset outputs",
        {27'd0, busy, done, pass, fail, rdReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && !rdReq, "R1", "after release",
        {27'd0, busy, done, pass, fail, rdReq}, 32'd0);

    runCase("R5 program bit7=1", 1'b0, 8'hA5, 18'h01234, 8, '{8'h05, 8'h05, 8'h85, 8'hA5}, 1'b0);
    runCase("R5 program bit7=0", 1'b0, 8'h3C, 18'h2AAAA, 8, '{8'h83, 8'h83, 8'h1C, 8'h3C}, 1'b0);
    runCase("R6 erase", 1'b1, 8'h00, 18'h10000, 8, '{8'h00, 8'h40, 8'h80, 8'hFF}, 1'b0);
    runCase("R6 match over limit", 1'b1, 8'h00, 18'h00F0F, 8, '{8'hA0, 8'h7E}, 1'b0);
    runCase("R7 immediate final", 1'b0, 8'h80, 18'h3FFFF, 8, '{8'h80, 8'h5A}, 1'b0);
    runCase("R8 confirm pass", 1'b0, 8'h80, 18'h00555, 8, '{8'h20, 8'h80, 8'h81}, 1'b0);
    runCase("R8 confirm fail", 1'b1, 8'h00, 18'h15555, 8, '{8'h60, 8'h20}, 1'b0);
    runCase("R9 budget", 1'b0, 8'h80, 18'h00100, 3, '{8'h00, 8'h01, 8'h02}, 1'b0);
    runCase("R9 zero budget", 1'b1, 8'h00, 18'h00200, 0, '{8'h11}, 1'b0);
    runCase("R2 start while busy", 1'b0, 8'hA5, 18'h0ABCD, 8, '{8'h05, 8'h05, 8'h85, 8'hA5}, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule